// File: doc/BRIEF.md
# Character LCD Scan Timing Generator

This block sequences the row multiplexing of a character dot-matrix LCD panel. It advances once per oscillator tick, given as a clock enable on the system clock. Each row period has two jobs. First, it fetches the pixel bits for the row that comes next, one bit per tick, from an external pixel source. Second, it shows the row fetched during the previous period on a latched segment word while the matching common line is selected. Pixels past the on-chip segment count leave on a serial data line with a shift clock for each bit and a latch clock for each row, so that cascaded external segment drivers can take them.

The duty setting selects 8, 11 or 16 active commons and the row length in ticks. A change of duty is taken only when a frame wraps. A polarity output makes the panel drive AC. In waveform type A it toggles on every row, and in type B it toggles on every frame. A display-enable input blanks the segment outputs and the extension data without touching the row data held by the block. Font lookup, character storage and bias voltages belong to the blocks around this one.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset, com_o selects COM1 (bit 0 only). seg_o, pol_o, ext_shift_o and ext_latch_o are 0, and the first frame runs in the 8-common mode.
- R2: duty_i encoding: 2'b00 gives 8 active commons, 2'b01 gives 11, and 2'b10 or 2'b11 gives 16. com_o is always one-hot. It advances by one bit at every row boundary and wraps from the last active common back to bit 0.
- R3: A row lasts ROW_CLKS_LONG oscillator ticks in the 8- and 11-common modes and ROW_CLKS_SHORT ticks in the 16-common mode. The last tick of a row is the row boundary.
- R4: On each of the first SEG_BITS+EXT_BITS ticks of a row, pix_req_o is high in the same cycle as osc_en_i and pix_idx_o counts 0 upward. fetch_row_o gives the index of the next common to be selected, which is 0 after the last active common. pix_i is sampled on that cycle. pix_req_o is never high without osc_en_i.
- R5: Pixel k of a row, for k < SEG_BITS, lands on seg_o[k]. The whole word becomes visible in the clock after the row boundary, together with the common it belongs to, and stays stable until the next boundary.
- R6: Pixel k of a row, for SEG_BITS <= k < SEG_BITS+EXT_BITS, appears on ext_data_o with a one-clock ext_shift_o pulse in the clock after its tick.
- R7: ext_latch_o pulses for one clock in the clock after each row boundary, which is the same clock in which com_o advances. com_o never changes without it.
- R8: With wave_b_i low (type A), pol_o toggles at every row boundary and at no other time.
- R9: With wave_b_i high (type B), pol_o toggles only at a frame boundary, that is, the row boundary of the last active common.
- R10: While disp_en_i is low, seg_o and ext_data_o read 0 at once. Setting disp_en_i high again restores the latched word unchanged.
- R11: duty_i is sampled only at a frame boundary. A change takes effect from the next frame, which starts at COM1 with the row counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator tick enable, one clock wide |
| duty_i | input | 2 | Duty select: 00 8 commons, 01 11 commons, 1x 16 commons |
| wave_b_i | input | 1 | Polarity waveform select: 0 row toggle, 1 frame toggle (static) |
| disp_en_i | input | 1 | Display enable; low blanks segment and extension data |
| pix_i | input | 1 | Pixel bit, valid while pix_req_o is high |
| pix_req_o | output | 1 | Pixel request strobe for this tick |
| pix_idx_o | output | $clog2(ROW_CLKS_LONG+1) | Index of the requested pixel within the row |
| fetch_row_o | output | $clog2(COMS_16) | Common index the fetched row belongs to |
| com_o | output | COMS_16 | One-hot common select |
| seg_o | output | SEG_BITS | Latched segment word |
| pol_o | output | 1 | Drive polarity (AC alternation) |
| ext_data_o | output | 1 | Serial data to extension drivers |
| ext_shift_o | output | 1 | Extension shift clock, one pulse per bit |
| ext_latch_o | output | 1 | Extension latch clock, one pulse per row |

## Verification
The bench builds the block with 24-tick and 16-tick rows, an 8-bit segment word and 4 extension bits. With these values a full 16-common frame is only 256 ticks, so many frames fit in one run. The run therefore covers many frame wraps, several duty changes that wait for a frame boundary, and both polarity types. The extension stream and the blanking input are exercised on every row, and the shortest row still leaves idle ticks between the last shift and the boundary.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    DUTY_8  = 2'b00,
    DUTY_11 = 2'b01,
    DUTY_16 = 2'b10
  } duty_e;

  function automatic logic is_short_row(input logic [1:0] d);
    return d[1];
  endfunction
endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer import lcd_scan_pkg::*; #(
  parameter int ROW_CLKS_LONG  = 400,
  parameter int ROW_CLKS_SHORT = 200,
  parameter int COMS_8         = 8,
  parameter int COMS_11        = 11,
  parameter int COMS_16        = 16,
  localparam int PW = $clog2(ROW_CLKS_LONG + 1),
  localparam int CW = $clog2(COMS_16)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          osc_en_i,
  input  logic [1:0]    duty_i,
  output logic [PW-1:0] phase_o,
  output logic          row_end_o,
  output logic          frame_end_o,
  output logic [CW-1:0] com_idx_o,
  output logic [CW-1:0] fetch_row_o
);
  logic [1:0]    duty_q;
  logic [PW-1:0] phase_q;
  logic [CW-1:0] com_q;
  logic [PW-1:0] last_phase;
  logic [CW-1:0] last_com;

  always_comb begin
    last_phase = is_short_row(duty_q) ? PW'(ROW_CLKS_SHORT - 1) : PW'(ROW_CLKS_LONG - 1);
    if (duty_q[1])      last_com = CW'(COMS_16 - 1);
    else if (duty_q[0]) last_com = CW'(COMS_11 - 1);
    else                last_com = CW'(COMS_8 - 1);
  end

  assign row_end_o   = osc_en_i && (phase_q == last_phase);
  assign frame_end_o = row_end_o && (com_q == last_com);
  assign phase_o     = phase_q;
  assign com_idx_o   = com_q;
  assign fetch_row_o = (com_q == last_com) ? '0 : com_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q  <= DUTY_8;
      phase_q <= '0;
      com_q   <= '0;
    end else if (row_end_o) begin
      phase_q <= '0;
      if (frame_end_o) begin
        com_q  <= '0;
        duty_q <= duty_i;  // new duty only at frame start
      end else begin
        com_q  <= com_q + CW'(1);
      end
    end else if (osc_en_i) begin
      phase_q <= phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter #(
  parameter int SEG_BITS = 40,
  parameter int EXT_BITS = 40,
  parameter int PW       = 9,
  localparam int TOTAL_BITS = SEG_BITS + EXT_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                osc_en_i,
  input  logic [PW-1:0]       phase_i,
  input  logic                row_end_i,
  input  logic                disp_en_i,
  input  logic                pix_i,
  output logic                pix_req_o,
  output logic [SEG_BITS-1:0] seg_o,
  output logic                ext_data_o,
  output logic                ext_shift_o,
  output logic                ext_latch_o
);
  logic                in_seg;
  logic [SEG_BITS-1:0] sreg_q;
  logic [SEG_BITS-1:0] seg_q;
  logic                latch_q;

  assign in_seg    = int'(phase_i) < SEG_BITS;
  assign pix_req_o = osc_en_i && (int'(phase_i) < TOTAL_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      seg_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      // first requested bit ends up in bit 0
      if (osc_en_i && in_seg) sreg_q <= {pix_i, sreg_q[SEG_BITS-1:1]};
      if (row_end_i)          seg_q  <= sreg_q;
      latch_q <= row_end_i;
    end
  end

  assign seg_o       = disp_en_i ? seg_q : '0;
  assign ext_latch_o = latch_q;

  generate
    if (EXT_BITS > 0) begin : g_ext
      logic in_ext;
      logic ext_d_q;
      logic ext_s_q;
      assign in_ext = !in_seg && (int'(phase_i) < TOTAL_BITS);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ext_d_q <= 1'b0;
          ext_s_q <= 1'b0;
        end else begin
          ext_s_q <= osc_en_i && in_ext;
          if (osc_en_i && in_ext) ext_d_q <= pix_i;
        end
      end
      assign ext_data_o  = disp_en_i && ext_d_q;
      assign ext_shift_o = ext_s_q;
    end else begin : g_no_ext
      assign ext_data_o  = 1'b0;
      assign ext_shift_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lcd_polarity.sv
module lcd_polarity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_end_i,
  input  logic frame_end_i,
  input  logic wave_b_i,
  output logic pol_o
);
  logic pol_q;
  logic flip;

  assign flip = wave_b_i ? frame_end_i : row_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pol_q <= 1'b0;
    else if (flip) pol_q <= ~pol_q;
  end

  assign pol_o = pol_q;
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int ROW_CLKS_LONG  = 400,
  parameter int ROW_CLKS_SHORT = 200,
  parameter int SEG_BITS       = 40,
  parameter int EXT_BITS       = 40,
  parameter int COMS_8         = 8,
  parameter int COMS_11        = 11,
  parameter int COMS_16        = 16,
  localparam int PW = $clog2(ROW_CLKS_LONG + 1),
  localparam int CW = $clog2(COMS_16)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                osc_en_i,
  input  logic [1:0]          duty_i,
  input  logic                wave_b_i,
  input  logic                disp_en_i,
  input  logic                pix_i,
  output logic                pix_req_o,
  output logic [PW-1:0]       pix_idx_o,
  output logic [CW-1:0]       fetch_row_o,
  output logic [COMS_16-1:0]  com_o,
  output logic [SEG_BITS-1:0] seg_o,
  output logic                pol_o,
  output logic                ext_data_o,
  output logic                ext_shift_o,
  output logic                ext_latch_o
);
  // the last shift must land before the row boundary
  if (SEG_BITS + EXT_BITS >= ROW_CLKS_SHORT || ROW_CLKS_SHORT > ROW_CLKS_LONG || SEG_BITS < 2)
    begin : g_bad_params
      initial $error("lcd_scan_timer: invalid parameter set");
    end

  logic [PW-1:0] phase;
  logic          row_end;
  logic          frame_end;
  logic [CW-1:0] com_idx;

  lcd_row_timer #(
    .ROW_CLKS_LONG (ROW_CLKS_LONG),
    .ROW_CLKS_SHORT(ROW_CLKS_SHORT),
    .COMS_8        (COMS_8),
    .COMS_11       (COMS_11),
    .COMS_16       (COMS_16)
  ) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .duty_i     (duty_i),
    .phase_o    (phase),
    .row_end_o  (row_end),
    .frame_end_o(frame_end),
    .com_idx_o  (com_idx),
    .fetch_row_o(fetch_row_o)
  );

  lcd_seg_shifter #(
    .SEG_BITS(SEG_BITS),
    .EXT_BITS(EXT_BITS),
    .PW      (PW)
  ) u_seg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .phase_i    (phase),
    .row_end_i  (row_end),
    .disp_en_i  (disp_en_i),
    .pix_i      (pix_i),
    .pix_req_o  (pix_req_o),
    .seg_o      (seg_o),
    .ext_data_o (ext_data_o),
    .ext_shift_o(ext_shift_o),
    .ext_latch_o(ext_latch_o)
  );

  lcd_polarity u_pol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_end_i  (row_end),
    .frame_end_i(frame_end),
    .wave_b_i   (wave_b_i),
    .pol_o      (pol_o)
  );

  assign pix_idx_o = phase;

  for (genvar g = 0; g < COMS_16; g++) begin : g_com
    assign com_o[g] = (com_idx == CW'(g));
  end
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int SEG_BITS = 40,
  parameter int NCOM     = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                osc_en_i,
  input logic                disp_en_i,
  input logic [NCOM-1:0]     com_o,
  input logic [SEG_BITS-1:0] seg_o,
  input logic                pol_o,
  input logic                pix_req_o,
  input logic                ext_shift_o,
  input logic                ext_latch_o
);
  AST_COM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(com_o) == 1); // R2

  AST_COM_MOVES_WITH_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(com_o) |-> ext_latch_o); // R7

  AST_LATCH_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_latch_o |-> $past(osc_en_i)); // R3

  AST_REQ_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> osc_en_i); // R4

  AST_SHIFT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_shift_o |-> $past(osc_en_i)); // R6

  AST_POL_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pol_o) |-> ext_latch_o); // R8

  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_latch_o && $stable(disp_en_i)) |-> $stable(seg_o)); // R5
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(
  .SEG_BITS(SEG_BITS),
  .NCOM    (COMS_16)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_en_i   (osc_en_i),
  .disp_en_i  (disp_en_i),
  .com_o      (com_o),
  .seg_o      (seg_o),
  .pol_o      (pol_o),
  .pix_req_o  (pix_req_o),
  .ext_shift_o(ext_shift_o),
  .ext_latch_o(ext_latch_o)
);

// File: tb/tb_lcd_scan_timer.sv
module tb_lcd_scan_timer;
  localparam int RL  = 24;
  localparam int RS  = 16;
  localparam int SB  = 8;
  localparam int EB  = 4;
  localparam int TOT = SB + EB;
  localparam int NC  = 16;
  localparam int PW  = $clog2(RL + 1);
  localparam int CW  = $clog2(NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0;
  logic [1:0] duty = 2'b00;
  logic wave_b = 1'b0;
  logic disp_en = 1'b1;
  logic pix = 1'b0;
  logic pix_req;
  logic [PW-1:0] pix_idx;
  logic [CW-1:0] fetch_row;
  logic [NC-1:0] com;
  logic [SB-1:0] seg;
  logic pol, ext_data, ext_shift, ext_latch;

  always #2 clk = ~clk;

  lcd_scan_timer #(
    .ROW_CLKS_LONG(RL), .ROW_CLKS_SHORT(RS), .SEG_BITS(SB), .EXT_BITS(EB),
    .COMS_8(8), .COMS_11(11), .COMS_16(NC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .duty_i(duty),
    .wave_b_i(wave_b), .disp_en_i(disp_en), .pix_i(pix),
    .pix_req_o(pix_req), .pix_idx_o(pix_idx), .fetch_row_o(fetch_row),
    .com_o(com), .seg_o(seg), .pol_o(pol), .ext_data_o(ext_data),
    .ext_shift_o(ext_shift), .ext_latch_o(ext_latch)
  );

  int errs = 0;
  int checks = 0;

  // model state
  int m_phase, m_com, m_frames;
  logic [1:0] m_duty;
  logic m_pol;
  logic [SB-1:0] m_sreg, m_seg;

  function automatic int row_len(input logic [1:0] d);
    return d[1] ? RS : RL;
  endfunction

  function automatic int n_com(input logic [1:0] d);
    return d[1] ? 16 : (d[0] ? 11 : 8);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_com = 0; m_duty = 2'b00; m_pol = 1'b0;
    m_sreg = '0; m_seg = '0; m_frames = 0;
  endtask

  task automatic apply_reset(input logic wb);
    @(negedge clk);
    rst_n = 1'b0; osc_en = 1'b0; wave_b = wb; disp_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    chk(com == 16'h0001, "R1", "com_o after reset", com, 16'h0001);
    chk(seg == '0, "R1", "seg_o after reset", seg, 0);
    chk(pol == 1'b0, "R1", "pol_o after reset", pol, 0);
    chk(!ext_shift && !ext_latch, "R1", "ext strobes after reset",
        {ext_shift, ext_latch}, 0);
    chk(!pix_req, "R4", "no request without tick", pix_req, 0);
  endtask

  // one oscillator tick followed by 1..3 idle clocks
  task automatic do_tick();
    int last_com, frow, rl;
    bit exp_req, exp_shift, exp_latch, exp_data;
    rl = row_len(m_duty);
    last_com = n_com(m_duty) - 1;
    frow = (m_com == last_com) ? 0 : m_com + 1;
    exp_req = m_phase < TOT;
    @(negedge clk);
    osc_en = 1'b1;
    pix = 1'($urandom);
    #1;
    chk(pix_req == exp_req, "R4", "pix_req_o", pix_req, exp_req);
    if (exp_req) begin
      chk(int'(pix_idx) == m_phase, "R4", "pix_idx_o", pix_idx, m_phase);
      chk(int'(fetch_row) == frow, "R4", "fetch_row_o", fetch_row, frow);
    end
    exp_shift = 1'b0; exp_data = 1'b0;
    if (m_phase < SB) m_sreg[m_phase] = pix;
    else if (m_phase < TOT) begin exp_shift = 1'b1; exp_data = pix; end
    exp_latch = (m_phase == rl - 1);
    if (exp_latch) begin
      m_seg = m_sreg;
      m_phase = 0;
      if (!wave_b) m_pol = ~m_pol;
      if (m_com == last_com) begin
        m_com = 0; m_duty = duty; m_frames++;
        if (wave_b) m_pol = ~m_pol;
      end else m_com++;
    end else m_phase++;
    @(negedge clk);
    osc_en = 1'b0;
    #1;
    chk(com == NC'(1 << m_com), "R2 R11", "com_o", com, 1 << m_com);
    chk(seg == (disp_en ? m_seg : '0), "R5 R10", "seg_o", seg, disp_en ? m_seg : 0);
    chk(pol == m_pol, wave_b ? "R9" : "R8", "pol_o", pol, m_pol);
    chk(ext_latch == exp_latch, "R3 R7", "ext_latch_o", ext_latch, exp_latch);
    chk(ext_shift == exp_shift, "R6", "ext_shift_o", ext_shift, exp_shift);
    if (exp_shift)
      chk(ext_data == (disp_en & exp_data), "R6 R10", "ext_data_o",
          ext_data, disp_en & exp_data);
    @(negedge clk);
    #1;
    chk(!ext_shift && !ext_latch, "R6 R7", "strobes one clock wide",
        {ext_shift, ext_latch}, 0);
    if ($urandom % 40 == 0) begin
      disp_en = ~disp_en;
      #1;
      chk(seg == (disp_en ? m_seg : '0), "R10", "seg_o after enable change",
          seg, disp_en ? m_seg : 0);
    end
    if ($urandom % 150 == 0) duty = 2'($urandom);
    repeat ($urandom % 3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1cd5_0a11));
    // type A, first frame in 8-common mode
    duty = 2'b10;  // must not act before the first wrap (R1, R11)
    apply_reset(1'b0);
    repeat (8 * RL) do_tick();
    chk(m_frames == 1 && com == 16'h0001, "R1", "8-common first frame wrap",
        com, 16'h0001);
    duty = 2'b11;  // 1x decodes as 16 commons (R2)
    repeat (16 * RS + 40) do_tick();
    duty = 2'b01;
    repeat (1500) do_tick();
    // type B
    duty = 2'b00;
    apply_reset(1'b1);
    repeat (1600) do_tick();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule